// File: doc/BRIEF.md
# Flash Command Decoder

This block interprets the command traffic that a host writes to a NOR-style flash array over an asynchronous parallel bus. The chip-enable, write-enable and output-enable strobes arrive as active-low levels that are already synchronous to the block clock. Each write strobe is closed when either chip-enable or write-enable rises, whichever is first. The address and data seen at that moment form one bus write. The block decodes the low byte of each write as a command. It keeps track of which source a bus read returns: array data, the status byte, identifier words or query data.

Program and erase are two-write sequences. When the second write arrives, the block hands address, data and operation kind to an external behavioural write engine through a start pulse. It then waits for a done pulse. While the engine runs, the block accepts only a status-read command or a suspend command, and reads return the status byte. Suspend and resume are supported for both operation kinds. After any program or erase, reads keep returning status until the host writes the read-array command.

Status byte layout: bit 7 ready (1) or busy (0); bit 6 erase suspended; bit 5 erase error; bit 4 program error; bit 2 program suspended; bits 3, 1 and 0 read as zero. A command-sequence error sets bits 5 and 4 together.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in read-array mode, the status byte reads 0x80 and neither the engine start nor the suspend output is asserted.
- R2: A bus write is taken when the first of chip-enable or write-enable rises while both were low. Address and data are those present in the last clock cycle in which both strobes were low, and later changes on the bus have no effect.
- R3: While output-enable or chip-enable is high, the output-enable flag is 0 and the read data port is all zeros.
- R4: Only the low byte of a write is decoded. 0xFF selects array reads, 0x70 selects status reads (byte zero-extended), 0x90 selects identifier reads and 0x98 selects query reads.
- R5: In identifier mode, the low 8 address bits pick the word: offset 0x00 returns the manufacturer code, 0x01 the device code, and 0x02 the addressed block's lock flag in bit 0. Other offsets return zero.
- R6: A write of 0x40, or of its alias 0x10, followed by any write issues a single-cycle start pulse. The pulse carries the program kind (erase flag 0) with the second write's address and data, and the block switches to status reads.
- R7: A write of 0x20 followed by 0xD0 issues a start pulse with the erase flag set and the second write's address. Any other second write issues no start, sets bits 5 and 4, and leaves the block in status reads.
- R8: While the engine is busy, status bit 7 reads 0 and reads return the status byte. Every command other than 0x70 and 0xB0 is ignored.
- R9: 0xB0 during a busy operation raises the suspend output and sets bit 7, plus bit 6 for an erase or bit 2 for a program. While suspended, the read-mode commands work. 0xD0 resumes: it clears the suspend bits and the suspend output, makes bit 7 read 0, and selects status reads.
- R10: When the engine's done pulse arrives, bit 7 returns to 1. If the fail input is high with it, bit 4 (program) or bit 5 (erase) is set. The block stays in status reads until 0xFF is written.
- R11: An unassigned command code leaves the read mode unchanged and sets status bits 5 and 4.
- R12: Error bits stay set across other commands until 0x50 is written. 0x50 clears bits 5 and 4 and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address from the bus |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data toward the bus, zero when not driven |
| dq_oe_o | output | 1 | High when the bus read data is driven |
| array_rdata_i | input | DATA_W | Array word at addr_i from the array model |
| query_rdata_i | input | DATA_W | Query word at addr_i from the query table |
| blk_locked_i | input | 1 | Lock flag of the block addressed by addr_i |
| eng_start_o | output | 1 | Single-cycle start toward the write engine |
| eng_erase_o | output | 1 | Operation kind: 1 erase, 0 program |
| eng_addr_o | output | ADDR_W | Target address of the operation |
| eng_data_o | output | DATA_W | Word to program |
| eng_suspend_o | output | 1 | Engine must pause while high |
| eng_done_i | input | 1 | Engine finished pulse |
| eng_fail_i | input | 1 | Qualifies eng_done_i as failed |

## Verification
A vector table writes each read-mode command and reads back through the new source. This separates array, status, identifier and query data by their distinct values, and it includes an unassigned code and a command carrying a non-zero high byte. Directed sequences run program through both setup codes and erase with a good confirm and with a bad one. They also cover suspend and resume for each operation kind, commands sent while the engine is busy, and done pulses with and without failure. Each case is told apart by the exact status byte it produces. One strobe pattern raises chip-enable first and then changes the data before write-enable rises, which shows whether the earlier or the later bus value was taken.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_PROG_SETUP  = 3'd1,
        ST_ERASE_SETUP = 3'd2,
        ST_BUSY        = 3'd3,
        ST_SUSPENDED   = 3'd4
    } seq_state_e;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_READ_IDENT  = 8'h90;
    localparam logic [7:0] CMD_READ_QUERY  = 8'h98;
    localparam logic [7:0] CMD_CLEAR_SR    = 8'h50;
    localparam logic [7:0] CMD_PROGRAM     = 8'h40;
    localparam logic [7:0] CMD_PROGRAM_ALT = 8'h10;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

    localparam logic [7:0] ID_OFF_MFR  = 8'h00;
    localparam logic [7:0] ID_OFF_DEV  = 8'h01;
    localparam logic [7:0] ID_OFF_LOCK = 8'h02;

    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic erase_err;
        logic prog_err;
        logic prog_susp;
    } status_t;

    typedef struct packed {
        logic     hit;
        rd_mode_e mode;
    } mode_sel_t;

    function automatic logic [7:0] status_byte(status_t s);
        return {s.ready, s.erase_susp, s.erase_err, s.prog_err,
                1'b0, s.prog_susp, 2'b00};
    endfunction

    function automatic mode_sel_t decode_read_cmd(logic [7:0] c);
        mode_sel_t r;
        r.hit  = 1'b1;
        r.mode = RD_ARRAY;
        unique case (c)
            CMD_READ_ARRAY:  r.mode = RD_ARRAY;
            CMD_READ_STATUS: r.mode = RD_STATUS;
            CMD_READ_IDENT:  r.mode = RD_IDENT;
            CMD_READ_QUERY:  r.mode = RD_QUERY;
            default:         r.hit  = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_program_setup(logic [7:0] c);
        return (c == CMD_PROGRAM) || (c == CMD_PROGRAM_ALT);
    endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    logic              strobe;
    logic              strobe_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;

    // A write is open only while both enables are low; the first one to
    // rise ends it.
    assign strobe = ~ce_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q    <= 1'b0;
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe) begin
                hold_addr_q <= addr_i;
                hold_data_q <= dq_i;
            end
        end
    end

    assign wr_valid_o = strobe_q & ~strobe;
    assign wr_addr_o  = hold_addr_q;
    assign wr_data_o  = hold_data_q;

    // R2: one commit per closed strobe
    p_single_commit_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |=> !wr_valid_o);

    // R2: held values do not move after the strobe has closed
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !strobe_q) |=> $stable(wr_data_o));

endmodule

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              eng_done_i,
    input  logic              eng_fail_i,
    output rd_mode_e          rd_mode_o,
    output logic [7:0]        status_o,
    output logic              eng_start_o,
    output logic              eng_erase_o,
    output logic [ADDR_W-1:0] eng_addr_o,
    output logic [DATA_W-1:0] eng_data_o,
    output logic              eng_suspend_o
);

    seq_state_e        state_q, state_d;
    rd_mode_e          mode_q, mode_d;
    status_t           sr_q, sr_d;
    logic              start_q, start_d;
    logic              erase_q, erase_d;
    logic [ADDR_W-1:0] eaddr_q, eaddr_d;
    logic [DATA_W-1:0] edata_q, edata_d;

    logic [7:0]        cmd;
    mode_sel_t         sel;

    assign cmd = wr_data_i[7:0];
    assign sel = decode_read_cmd(cmd);

    always_comb begin
        seq_state_e st;
        st      = state_q;
        state_d = state_q;
        mode_d  = mode_q;
        sr_d    = sr_q;
        start_d = 1'b0;
        erase_d = erase_q;
        eaddr_d = eaddr_q;
        edata_d = edata_q;

        // Completion first, so a write in the same cycle sees an idle block.
        if (state_q == ST_BUSY && eng_done_i) begin
            sr_d.ready = 1'b1;
            if (eng_fail_i) begin
                if (erase_q) sr_d.erase_err = 1'b1;
                else         sr_d.prog_err  = 1'b1;
            end
            st      = ST_IDLE;
            state_d = ST_IDLE;
        end

        if (wr_valid_i) begin
            unique case (st)
                ST_IDLE: begin
                    if (sel.hit) begin
                        mode_d = sel.mode;
                    end else if (cmd == CMD_CLEAR_SR) begin
                        sr_d.erase_err = 1'b0;
                        sr_d.prog_err  = 1'b0;
                    end else if (is_program_setup(cmd)) begin
                        state_d = ST_PROG_SETUP;
                        mode_d  = RD_STATUS;
                    end else if (cmd == CMD_ERASE) begin
                        state_d = ST_ERASE_SETUP;
                        mode_d  = RD_STATUS;
                    end else if (cmd == CMD_SUSPEND) begin
                        mode_d = mode_q;
                    end else begin
                        sr_d.erase_err = 1'b1;
                        sr_d.prog_err  = 1'b1;
                    end
                end
                ST_PROG_SETUP: begin
                    start_d    = 1'b1;
                    erase_d    = 1'b0;
                    eaddr_d    = wr_addr_i;
                    edata_d    = wr_data_i;
                    sr_d.ready = 1'b0;
                    state_d    = ST_BUSY;
                    mode_d     = RD_STATUS;
                end
                ST_ERASE_SETUP: begin
                    mode_d = RD_STATUS;
                    if (cmd == CMD_CONFIRM) begin
                        start_d    = 1'b1;
                        erase_d    = 1'b1;
                        eaddr_d    = wr_addr_i;
                        edata_d    = '0;
                        sr_d.ready = 1'b0;
                        state_d    = ST_BUSY;
                    end else begin
                        sr_d.erase_err = 1'b1;
                        sr_d.prog_err  = 1'b1;
                        state_d        = ST_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (cmd == CMD_SUSPEND) begin
                        state_d    = ST_SUSPENDED;
                        sr_d.ready = 1'b1;
                        if (erase_q) sr_d.erase_susp = 1'b1;
                        else         sr_d.prog_susp  = 1'b1;
                    end else if (cmd == CMD_READ_STATUS) begin
                        mode_d = RD_STATUS;
                    end
                end
                ST_SUSPENDED: begin
                    if (sel.hit) begin
                        mode_d = sel.mode;
                    end else if (cmd == CMD_CLEAR_SR) begin
                        sr_d.erase_err = 1'b0;
                        sr_d.prog_err  = 1'b0;
                    end else if (cmd == CMD_CONFIRM) begin
                        state_d         = ST_BUSY;
                        sr_d.ready      = 1'b0;
                        sr_d.erase_susp = 1'b0;
                        sr_d.prog_susp  = 1'b0;
                        mode_d          = RD_STATUS;
                    end else if (is_program_setup(cmd) || cmd == CMD_ERASE ||
                                 cmd == CMD_SUSPEND) begin
                        mode_d = mode_q;
                    end else begin
                        sr_d.erase_err = 1'b1;
                        sr_d.prog_err  = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= RD_ARRAY;
            sr_q    <= '{ready: 1'b1, default: 1'b0};
            start_q <= 1'b0;
            erase_q <= 1'b0;
            eaddr_q <= '0;
            edata_q <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            sr_q    <= sr_d;
            start_q <= start_d;
            erase_q <= erase_d;
            eaddr_q <= eaddr_d;
            edata_q <= edata_d;
        end
    end

    assign rd_mode_o     = mode_q;
    assign status_o      = status_byte(sr_q);
    assign eng_start_o   = start_q;
    assign eng_erase_o   = erase_q;
    assign eng_addr_o    = eaddr_q;
    assign eng_data_o    = edata_q;
    assign eng_suspend_o = (state_q == ST_SUSPENDED);

    // R6: start is a single-cycle pulse
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o);

    // R6: a started operation is busy and reads status
    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> (!sr_q.ready && mode_q == RD_STATUS));

    // R8: busy always reads status
    p_busy_status_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY) |-> (mode_q == RD_STATUS && !sr_q.ready));

    // R9: suspended operation reports ready with one suspend flag
    p_suspend_flags_r9: assert property (@(posedge clk) disable iff (rst)
        eng_suspend_o |-> (sr_q.ready && $countones({sr_q.erase_susp, sr_q.prog_susp}) == 1));

    // R12: erase error persists until cleared
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (sr_q.erase_err && !(wr_valid_i && cmd == CMD_CLEAR_SR)) |=> sr_q.erase_err);

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
    import fcd_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h0031,
    parameter logic [15:0] DEV_CODE = 16'h88C4
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  rd_mode_e          mode_i,
    input  logic [7:0]        id_off_i,
    input  logic [7:0]        status_i,
    input  logic [DATA_W-1:0] array_rdata_i,
    input  logic [DATA_W-1:0] query_rdata_i,
    input  logic              blk_locked_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    localparam int PAD_W = DATA_W - 8;

    logic [DATA_W-1:0] ident_word;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        unique case (id_off_i)
            ID_OFF_MFR:  ident_word = DATA_W'(MFR_CODE);
            ID_OFF_DEV:  ident_word = DATA_W'(DEV_CODE);
            ID_OFF_LOCK: ident_word = {{(DATA_W-1){1'b0}}, blk_locked_i};
            default:     ident_word = '0;
        endcase
    end

    always_comb begin
        unique case (mode_i)
            RD_ARRAY:  rd_word = array_rdata_i;
            RD_STATUS: rd_word = {{PAD_W{1'b0}}, status_i};
            RD_IDENT:  rd_word = ident_word;
            RD_QUERY:  rd_word = query_rdata_i;
            default:   rd_word = '0;
        endcase
    end

    assign dq_oe_o = ~ce_n & ~oe_n;
    assign dq_o    = dq_oe_o ? rd_word : '0;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W   = 19,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h0031,
    parameter logic [15:0] DEV_CODE = 16'h88C4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    input  logic [DATA_W-1:0] array_rdata_i,
    input  logic [DATA_W-1:0] query_rdata_i,
    input  logic              blk_locked_i,
    output logic              eng_start_o,
    output logic              eng_erase_o,
    output logic [ADDR_W-1:0] eng_addr_o,
    output logic [DATA_W-1:0] eng_data_o,
    output logic              eng_suspend_o,
    input  logic              eng_done_i,
    input  logic              eng_fail_i
);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    rd_mode_e          rd_mode;
    logic [7:0]        status;

    fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .addr_i     (addr_i),
        .dq_i       (dq_i),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    fcd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .wr_valid_i    (wr_valid),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .eng_done_i    (eng_done_i),
        .eng_fail_i    (eng_fail_i),
        .rd_mode_o     (rd_mode),
        .status_o      (status),
        .eng_start_o   (eng_start_o),
        .eng_erase_o   (eng_erase_o),
        .eng_addr_o    (eng_addr_o),
        .eng_data_o    (eng_data_o),
        .eng_suspend_o (eng_suspend_o)
    );

    fcd_read_mux #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .mode_i        (rd_mode),
        .id_off_i      (addr_i[7:0]),
        .status_i      (status),
        .array_rdata_i (array_rdata_i),
        .query_rdata_i (query_rdata_i),
        .blk_locked_i  (blk_locked_i),
        .dq_o          (dq_o),
        .dq_oe_o       (dq_oe_o)
    );

    // R3: undriven bus carries no data
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (oe_n || ce_n) |-> (!dq_oe_o && dq_o == '0));

    // R9: the engine is never started while held in suspend
    p_no_start_in_suspend_r9: assert property (@(posedge clk) disable iff (rst)
        eng_suspend_o |-> !eng_start_o);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam int DATA_W     = 16;
    localparam int ENG_LAT    = 8;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 11;

    // {write data, read address, expected read}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'h0070, 16'h0010, 16'h0080},
        {16'h0090, 16'h8002, 16'h0001},
        {16'h0090, 16'h0002, 16'h0000},
        {16'h0090, 16'h0000, 16'h0031},
        {16'h0090, 16'h0001, 16'h88C4},
        {16'h00FF, 16'h0123, 16'h5B79},
        {16'h0098, 16'h0010, 16'hC010},
        {16'h003C, 16'h0010, 16'hC010},
        {16'hAB70, 16'h0010, 16'h00B0},
        {16'h0050, 16'h0010, 16'h0080},
        {16'h00FF, 16'h0020, 16'h5A7A}
    };
    string vtag [NVEC] = '{"R1", "R5", "R5", "R5", "R5", "R4", "R4",
                           "R11", "R4", "R12", "R4"};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] dq_i = '0;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe_o;
    logic [DATA_W-1:0] array_rdata_i, query_rdata_i;
    logic              blk_locked_i;
    logic              eng_start_o, eng_erase_o, eng_suspend_o;
    logic [ADDR_W-1:0] eng_addr_o;
    logic [DATA_W-1:0] eng_data_o;
    logic              eng_done_i = 1'b0, eng_fail_i = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    bit fail_next = 1'b0;
    logic [DATA_W-1:0] rd;

    assign array_rdata_i = addr_i[15:0] ^ 16'h5A5A;
    assign query_rdata_i = 16'hC000 | {8'h00, addr_i[7:0]};
    assign blk_locked_i  = addr_i[15];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .array_rdata_i(array_rdata_i), .query_rdata_i(query_rdata_i),
        .blk_locked_i(blk_locked_i), .eng_start_o(eng_start_o),
        .eng_erase_o(eng_erase_o), .eng_addr_o(eng_addr_o),
        .eng_data_o(eng_data_o), .eng_suspend_o(eng_suspend_o),
        .eng_done_i(eng_done_i), .eng_fail_i(eng_fail_i)
    );

    // Behavioural engine: counts down while not suspended, then pulses done.
    int  eng_cnt = 0;
    bit  eng_busy = 1'b0;
    always @(negedge clk) begin
        eng_done_i = 1'b0;
        eng_fail_i = 1'b0;
        if (eng_start_o) begin
            eng_busy = 1'b1;
            eng_cnt  = ENG_LAT;
        end else if (eng_busy && !eng_suspend_o) begin
            if (eng_cnt == 0) begin
                eng_done_i = 1'b1;
                eng_fail_i = fail_next;
                eng_busy   = 1'b0;
            end else begin
                eng_cnt = eng_cnt - 1;
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        addr_i = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        addr_i = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        v = dq_o;
        ce_n = 1'b1; oe_n = 1'b1;
        #1;
    endtask

    task automatic wait_engine();
        repeat (ENG_LAT + 6) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 start idle", eng_start_o, 0);
        check("R1 suspend idle", eng_suspend_o, 0);
        bus_read(19'h00010, rd);
        check("R1 array after reset", rd, 16'h5A4A);

        // R3: output enable high keeps the bus quiet
        addr_i = 19'h00010; ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R3 oe flag", dq_oe_o, 0);
        check("R3 data zero", dq_o, 0);
        oe_n = 1'b0; #1;
        check("R3 oe flag on", dq_oe_o, 1);
        ce_n = 1'b1; oe_n = 1'b1;

        // Table walk: mode commands, identifier words, unknown code, clear
        for (int i = 0; i < NVEC; i++) begin
            bus_write('0, VEC[i][47:32]);
            bus_read({3'b000, VEC[i][31:16]}, rd);
            check(vtag[i], rd, VEC[i][15:0]);
        end

        // R6: program through 0x40
        bus_write('0, 16'h0040);
        bus_write(19'h00456, 16'h1234);
        check("R6 start", eng_start_o, 1);
        check("R6 kind", eng_erase_o, 0);
        check("R6 addr", eng_addr_o, 19'h00456);
        check("R6 data", eng_data_o, 16'h1234);
        bus_read('0, rd);
        check("R8 busy status", rd, 16'h0000);
        bus_write('0, 16'h00FF);
        bus_read(19'h00123, rd);
        check("R8 command ignored while busy", rd, 16'h0000);
        wait_engine();
        bus_read(19'h00123, rd);
        check("R10 done stays status", rd, 16'h0080);
        bus_write('0, 16'h00FF);
        bus_read(19'h00010, rd);
        check("R10 array after FF", rd, 16'h5A4A);

        // R6: alias code
        bus_write('0, 16'h0010);
        bus_write(19'h00777, 16'hBEEF);
        check("R6 alias start", eng_start_o, 1);
        check("R6 alias data", eng_data_o, 16'hBEEF);
        wait_engine();

        // R7 R9 R10 R12: erase with suspend, array read, resume, failure
        fail_next = 1'b1;
        bus_write('0, 16'h0020);
        bus_write(19'h08000, 16'h00D0);
        check("R7 erase start", eng_start_o, 1);
        check("R7 erase kind", eng_erase_o, 1);
        check("R7 erase addr", eng_addr_o, 19'h08000);
        bus_write('0, 16'h00B0);
        check("R9 suspend out", eng_suspend_o, 1);
        bus_read('0, rd);
        check("R9 erase suspended status", rd, 16'h00C0);
        bus_write('0, 16'h00FF);
        bus_read(19'h00123, rd);
        check("R9 array in suspend", rd, 16'h5B79);
        bus_write('0, 16'h00D0);
        check("R9 resume releases", eng_suspend_o, 0);
        bus_read('0, rd);
        check("R9 resume busy status", rd, 16'h0000);
        wait_engine();
        bus_read('0, rd);
        check("R10 erase fail", rd, 16'h00A0);
        fail_next = 1'b0;
        bus_write('0, 16'h00FF);
        bus_write('0, 16'h0070);
        bus_read('0, rd);
        check("R12 error persists", rd, 16'h00A0);
        bus_write('0, 16'h0050);
        bus_read('0, rd);
        check("R12 cleared", rd, 16'h0080);

        // R7: bad confirm
        bus_write('0, 16'h0020);
        bus_write('0, 16'h00FF);
        check("R7 no start on bad confirm", eng_start_o, 0);
        bus_read(19'h00123, rd);
        check("R7 sequence error", rd, 16'h00B0);
        bus_write('0, 16'h0050);

        // R9: program suspend
        bus_write('0, 16'h0040);
        bus_write(19'h00100, 16'h5555);
        bus_write('0, 16'h00B0);
        bus_read('0, rd);
        check("R9 program suspended status", rd, 16'h0084);
        bus_write('0, 16'h00D0);
        wait_engine();
        bus_read('0, rd);
        check("R10 program done", rd, 16'h0080);

        // R2: chip enable rises first, data changes before write enable rises
        bus_write('0, 16'h00FF);
        @(negedge clk);
        addr_i = '0; dq_i = 16'h0090; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        dq_i = 16'h0098;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        bus_read(19'h00000, rd);
        check("R2 first rising edge capture", rd, 16'h0031);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule